// File: doc/BRIEF.md
# Compare Output Pin Unit

This block sits between a timer's compare-match logic and a set of general-purpose I/O pins. Each channel holds one output-compare level flop. A compare-match pulse or a force strobe updates that flop, and a 2-bit action field chooses the update: leave it, invert it, drive it low or drive it high. A preset input lets software load the level directly before the channel is routed to its pin.

The same action field also selects what the pin shows. When the field is zero, the pin carries the ordinary port data bit. When the field is nonzero, the pin carries the compare level. The pin's output enable always follows the channel's direction bit, whatever the action field holds. The number of channels is a parameter, and every channel works on its own.

Top module: `ocu_pin_unit`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, every channel's compare level (level_o) reads 0.
- R2: In a cycle with no match, no force and no preset, a channel's compare level keeps its value.
- R3: With action field 2'b00, a match or a force leaves the compare level unchanged.
- R4: With action field 2'b01, a match or a force inverts the compare level at the next clock edge.
- R5: With action field 2'b10, a match or a force makes the compare level 0 at the next clock edge.
- R6: With action field 2'b11, a match or a force makes the compare level 1 at the next clock edge.
- R7: A force strobe has the same effect as a match. A match and a force in the same cycle apply the action only once.
- R8: When preset_en is high, the compare level takes preset_val at the next edge. This has priority over any match or force in that cycle.
- R9: The pin value (pin_o) equals the compare level when the channel's action field is nonzero, and the port data bit when it is 2'b00. The pin value follows these sources combinationally.
- R10: The pin output enable (pin_oe_o) equals the channel's direction bit in every mode. With direction 0 the pin is tri-stated even if the action field is nonzero.
- R11: Channels are independent. Channel c uses the action field bits [2c+1:2c] and only its own bit of every other per-channel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_i | input | CHANNELS | Compare-match pulse per channel |
| force_i | input | CHANNELS | Force strobe per channel |
| action_i | input | 2*CHANNELS | Action field per channel, channel c at [2c+1:2c] |
| port_data_i | input | CHANNELS | Port data register bit per channel |
| dir_i | input | CHANNELS | Direction bit per channel, 1 means output |
| preset_en_i | input | CHANNELS | Load preset_val into the compare level |
| preset_val_i | input | CHANNELS | Value loaded by preset |
| pin_o | output | CHANNELS | Value driven to the pin |
| pin_oe_o | output | CHANNELS | Pin output enable |
| level_o | output | CHANNELS | Internal compare level |

## Verification
The bench builds the unit with CHANNELS = 3 rather than the default of 2. With three channels, a middle channel sits between two neighbours, so a slicing error in the action field or a crossed per-channel bit shows up on the idle channels. Channel 0 walks a table that covers each action under match, under force, under both together and under preset collisions, with the direction bit toggled. The other two channels are then driven at the same time with different actions to show they do not affect one another.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_INVERT = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } ocu_action_e;

    typedef struct packed {
        logic level;
    } ocu_state_t;

    function automatic logic ocu_apply(input ocu_action_e act, input logic cur);
        logic nxt;
        case (act)
            ACT_INVERT: nxt = ~cur;
            ACT_LOW:    nxt = 1'b0;
            ACT_HIGH:   nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ocu_level_reg.sv
module ocu_level_reg
    import ocu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] action_i,
    input  logic       preset_en_i,
    input  logic       preset_val_i,
    output logic       level_o
);

    ocu_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset_en_i) begin
            st_d.level = preset_val_i;
        end else if (trig_i) begin
            st_d.level = ocu_apply(ocu_action_e'(action_i), st_q.level);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/ocu_pin_route.sv
module ocu_pin_route
    import ocu_pkg::*;
(
    input  logic [1:0] action_i,
    input  logic       level_i,
    input  logic       port_data_i,
    input  logic       dir_i,
    output logic       pin_o,
    output logic       pin_oe_o
);

    logic override;

    always_comb begin
        override = (ocu_action_e'(action_i) != ACT_KEEP);
        pin_o    = override ? level_i : port_data_i;
        pin_oe_o = dir_i;
    end

endmodule

// File: rtl/ocu_pin_unit.sv
module ocu_pin_unit #(
    parameter int CHANNELS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CHANNELS-1:0]   match_i,
    input  logic [CHANNELS-1:0]   force_i,
    input  logic [2*CHANNELS-1:0] action_i,
    input  logic [CHANNELS-1:0]   port_data_i,
    input  logic [CHANNELS-1:0]   dir_i,
    input  logic [CHANNELS-1:0]   preset_en_i,
    input  logic [CHANNELS-1:0]   preset_val_i,
    output logic [CHANNELS-1:0]   pin_o,
    output logic [CHANNELS-1:0]   pin_oe_o,
    output logic [CHANNELS-1:0]   level_o
);

    localparam int ACT_W = 2;

    logic [CHANNELS-1:0] trig;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        assign trig[c] = match_i[c] | force_i[c];

        ocu_level_reg u_level (
            .clk          (clk),
            .rst_n        (rst_n),
            .trig_i       (trig[c]),
            .action_i     (action_i[ACT_W*c +: ACT_W]),
            .preset_en_i  (preset_en_i[c]),
            .preset_val_i (preset_val_i[c]),
            .level_o      (level_o[c])
        );

        ocu_pin_route u_route (
            .action_i    (action_i[ACT_W*c +: ACT_W]),
            .level_i     (level_o[c]),
            .port_data_i (port_data_i[c]),
            .dir_i       (dir_i[c]),
            .pin_o       (pin_o[c]),
            .pin_oe_o    (pin_oe_o[c])
        );
    end

endmodule

// File: rtl/ocu_pin_unit_chk.sv
module ocu_pin_unit_chk #(
    parameter int CHANNELS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CHANNELS-1:0]   match_i,
    input logic [CHANNELS-1:0]   force_i,
    input logic [2*CHANNELS-1:0] action_i,
    input logic [CHANNELS-1:0]   port_data_i,
    input logic [CHANNELS-1:0]   preset_en_i,
    input logic [CHANNELS-1:0]   preset_val_i,
    input logic [CHANNELS-1:0]   pin_o,
    input logic [CHANNELS-1:0]   level_o
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
        logic       hit;
        logic [1:0] act;
        assign hit = match_i[c] | force_i[c];
        assign act = action_i[2*c +: 2];

        p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && !preset_en_i[c]) |=> $stable(level_o[c]));

        p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && act == 2'b00 && !preset_en_i[c]) |=> $stable(level_o[c]));

        p_invert_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && act == 2'b01 && !preset_en_i[c]) |=> (level_o[c] != $past(level_o[c])));

        p_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && act == 2'b10 && !preset_en_i[c]) |=> (level_o[c] == 1'b0));

        p_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && act == 2'b11 && !preset_en_i[c]) |=> (level_o[c] == 1'b1));

        p_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
            preset_en_i[c] |=> (level_o[c] == $past(preset_val_i[c])));

        p_pin_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (act != 2'b00) |-> (pin_o[c] == level_o[c]));

        p_pin_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (act == 2'b00) |-> (pin_o[c] == port_data_i[c]));
    end

endmodule

bind ocu_pin_unit ocu_pin_unit_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .match_i      (match_i),
    .force_i      (force_i),
    .action_i     (action_i),
    .port_data_i  (port_data_i),
    .preset_en_i  (preset_en_i),
    .preset_val_i (preset_val_i),
    .pin_o        (pin_o),
    .level_o      (level_o)
);

// File: tb/sim_ocu_pin_unit.sv
`timescale 1ns/1ps
module sim_ocu_pin_unit;

    localparam int CH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CH-1:0]   match_i = '0;
    logic [CH-1:0]   force_i = '0;
    logic [2*CH-1:0] action_i = '0;
    logic [CH-1:0]   port_data_i = '0;
    logic [CH-1:0]   dir_i = '0;
    logic [CH-1:0]   preset_en_i = '0;
    logic [CH-1:0]   preset_val_i = '0;
    logic [CH-1:0]   pin_o, pin_oe_o, level_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ocu_pin_unit #(.CHANNELS(CH)) u0 (
        .clk(clk), .rst_n(rst_n), .match_i(match_i), .force_i(force_i),
        .action_i(action_i), .port_data_i(port_data_i), .dir_i(dir_i),
        .preset_en_i(preset_en_i), .preset_val_i(preset_val_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o), .level_o(level_o)
    );

    // {preset_en, preset_val, match, force, action[1:0], port, dir, exp_level, exp_pin, exp_oe}
    localparam logic [10:0] VEC [12] = '{
        11'b0010_0101_111, // R4 invert by match
        11'b0001_0101_001, // R4 R7 invert by force
        11'b0010_1101_111, // R6 high by match
        11'b0010_0000_100, // R3 keep, pin from port, R10 oe low
        11'b0001_0011_111, // R3 keep by force, pin from port
        11'b0010_1001_001, // R5 low by match
        11'b1100_1001_111, // R8 preset to 1
        11'b0011_0101_001, // R7 match and force invert once
        11'b1010_1101_001, // R8 preset 0 beats match with high action
        11'b0000_0111_001, // R2 hold, R9 pin from level not port
        11'b0010_0100_110, // R10 tri-stated while action nonzero
        11'b0000_0001_101  // R2 hold, R9 pin from port when keep
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        #7;
        for (int c = 0; c < CH; c++) check("R1 reset level", level_o[c], 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            preset_en_i[0]  = VEC[i][10];
            preset_val_i[0] = VEC[i][9];
            match_i[0]      = VEC[i][8];
            force_i[0]      = VEC[i][7];
            action_i[1:0]   = VEC[i][6:5];
            port_data_i[0]  = VEC[i][4];
            dir_i[0]        = VEC[i][3];
            @(posedge clk);
            #1;
            check("R3-R8 vector level", level_o[0], VEC[i][2]);
            check("R9 vector pin", pin_o[0], VEC[i][1]);
            check("R10 vector oe", pin_oe_o[0], VEC[i][0]);
            check("R11 idle ch1", level_o[1], 1'b0);
            check("R11 idle ch2", level_o[2], 1'b0);
            match_i = '0;
            force_i = '0;
            preset_en_i = '0;
        end

        // R11: neighbours driven together with different actions
        @(negedge clk);
        action_i = {2'b11, 2'b01, 2'b00};
        force_i  = 3'b010;
        match_i  = 3'b101;
        dir_i    = 3'b110;
        port_data_i = 3'b000;
        @(posedge clk);
        #1;
        check("R11 ch0 keep", level_o[0], 1'b1);
        check("R11 ch1 invert", level_o[1], 1'b1);
        check("R11 ch2 high", level_o[2], 1'b1);
        check("R10 ch0 oe", pin_oe_o[0], 1'b0);
        check("R10 ch2 oe", pin_oe_o[2], 1'b1);
        check("R9 ch0 port", pin_o[0], 1'b0);
        match_i = '0;
        force_i = '0;

        // R2: several idle cycles hold every level
        for (int k = 0; k < 3; k++) @(posedge clk);
        #1;
        check("R2 ch1 hold", level_o[1], 1'b1);
        check("R2 ch2 hold", level_o[2], 1'b1);

        // R9: pin follows port data combinationally in keep mode
        @(negedge clk);
        port_data_i[0] = 1'b1;
        #0.5;
        check("R9 ch0 port live", pin_o[0], 1'b1);

        // R1: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int c = 0; c < CH; c++) check("R1 async reset", level_o[c], 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule